// File: doc/BRIEF.md
# Lane-Split Parallel CRC-32 Engine

This block computes a 32-bit cyclic redundancy check over a packet stream that arrives sixteen bytes per clock on a 128-bit datapath. That is enough to keep pace with a 40 Gb/s link at a 312.5 MHz clock. The engine never applies back-pressure, so a packet can be streamed at line rate with no idle cycles.

Each beat is divided into four 32-bit lanes. Each lane's contribution is found as though the other lanes held zeros, and the four results are merged by XOR. The running register, advanced across the beat, is folded in the same way. Because the register starts from zero, the merge needs no constant correction term.

A short final beat is handled by moving its valid bytes to the top of the beat. The same lane logic is then reused, and only the register advance depends on the byte count. The checksum is the bit-inverted register. It is presented with a one-cycle done pulse after the closing beat.

Top module: `lcrc_lane_engine`

## Requirements
- R1: The checksum uses the reflected polynomial 0xEDB88320. Each byte is taken least significant bit first, and byte 0 sits on `in_data[7:0]` and enters first. The register is zero at the start of every packet, and `crc_out` is the bitwise inverse of the register.
- R2: Back-pressure rule: `in_ready` is low while `rst` is high. It is high from the first clock edge after `rst` falls and stays high from then on. A beat is taken on every edge where `in_valid` and `in_ready` are both high, so the source never has to hold a beat for more than one cycle once out of reset.
- R3: An accepted beat with `in_sop` high discards any earlier accumulation and restarts from zero before that beat is absorbed. A single beat that has both `in_sop` and `in_eop` high is a complete packet.
- R4: On an accepted beat with `in_eop` high, a value n of 1 to 16 on `in_nbytes` means that only bytes 0 to n-1 are included, and bytes n to 15 have no effect. The values 0 and 17 to 31 are taken as 16.
- R5: On accepted beats with `in_eop` low, `in_nbytes` is ignored and all 16 bytes are absorbed.
- R6: `crc_done` is high for exactly one cycle, in the cycle after an accepted beat with `in_eop` high. `crc_out` carries that packet's checksum from the same cycle.
- R7: `crc_out` changes only in a cycle where `crc_done` is high. It keeps its value through idle cycles and through the beats of the next packet.
- R8: A cycle with `in_valid` low has no effect, whatever the values on `in_data`, `in_sop`, `in_eop` and `in_nbytes`. It raises no done pulse and leaves the running result unchanged.
- R9: While `rst` is high, `crc_done` is 0 and `crc_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Beat present on the input |
| in_ready | output | 1 | Engine accepts a beat this cycle |
| in_data | input | 128 | Beat payload, byte 0 on bits [7:0] |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_nbytes | input | 5 | Valid byte count on the last beat |
| crc_out | output | 32 | Inverted checksum of the last finished packet |
| crc_done | output | 1 | One-cycle pulse when `crc_out` is updated |

## Verification
On every cycle, the assertions check the handshake and the output timing. They check that a done pulse follows each accepted closing beat and nothing else, that idle cycles raise no pulse, that the output only moves together with the pulse, that ready returns after reset, and the reset values. Whether the checksum value itself is right can only be shown by the bench's scenarios. These compare the output with a bit-serial model for every tail length from 1 to 16 and for longer packets. They also show that garbage in unused tail bytes, in the count on inner beats and in idle cycles changes nothing, and that a start marker discards stale beats.

// File: rtl/lcrc_pkg.sv
package lcrc_pkg;

  localparam int CRC_W = 32;

  typedef logic [CRC_W-1:0] crc_t;
  typedef logic [CRC_W-1:0][CRC_W-1:0] crc_mat_t;

  // Push nbits zero bits through a reflected LFSR.
  function automatic crc_t zero_adv(crc_t s, int nbits, crc_t poly);
    crc_t r;
    r = s;
    for (int i = 0; i < nbits; i++) begin
      r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    end
    return r;
  endfunction

  // Multiply a square GF(2) matrix (stored by column) by a vector.
  function automatic crc_t mat_vec(crc_mat_t m, crc_t v);
    crc_t r;
    r = '0;
    for (int j = 0; j < CRC_W; j++) begin
      if (v[j]) r = r ^ m[j];
    end
    return r;
  endfunction

endpackage

// File: rtl/lcrc_tail_align.sv
module lcrc_tail_align #(
  parameter int BEAT_BYTES = 16,
  localparam int DATA_W = BEAT_BYTES * 8,
  localparam int CNT_W  = $clog2(BEAT_BYTES + 1)
) (
  input  logic [DATA_W-1:0] data,
  input  logic              is_last,
  input  logic [CNT_W-1:0]  nbytes,
  output logic [DATA_W-1:0] aligned,
  output logic [CNT_W-1:0]  eff_n
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(BEAT_BYTES);

  logic [CNT_W-1:0] shamt;

  // Leading zero bytes leave a zero register untouched, so a short tail
  // shifted to the top of the beat reuses the full-beat lane matrices.
  always_comb begin
    eff_n = FULL;
    if (is_last && (nbytes != '0) && (nbytes <= FULL)) eff_n = nbytes;
    shamt   = FULL - eff_n;
    aligned = data << {shamt, 3'b000};
  end

endmodule

// File: rtl/lcrc_lane_contrib.sv
module lcrc_lane_contrib
  import lcrc_pkg::*;
#(
  parameter int   BEAT_BYTES = 16,
  parameter int   LANE_BYTES = 4,
  parameter int   LANE_IDX   = 0,
  parameter crc_t POLY       = 32'hEDB88320,
  localparam int  LANE_W     = LANE_BYTES * 8,
  localparam int  BEAT_W     = BEAT_BYTES * 8
) (
  input  logic [LANE_W-1:0] lane_data,
  output crc_t              contrib
);

  typedef logic [LANE_W-1:0][CRC_W-1:0] lane_mat_t;

  // Column j: checksum of a beat whose only set bit is this lane's bit j.
  function automatic lane_mat_t build_lane();
    lane_mat_t m;
    for (int j = 0; j < LANE_W; j++) begin
      m[j] = zero_adv(POLY, BEAT_W - 1 - (LANE_IDX * LANE_W + j), POLY);
    end
    return m;
  endfunction

  localparam lane_mat_t LANE_M = build_lane();

  always_comb begin
    contrib = '0;
    for (int j = 0; j < LANE_W; j++) begin
      if (lane_data[j]) contrib = contrib ^ LANE_M[j];
    end
  end

endmodule

// File: rtl/lcrc_state_adv.sv
module lcrc_state_adv
  import lcrc_pkg::*;
#(
  parameter int   BEAT_BYTES = 16,
  parameter crc_t POLY       = 32'hEDB88320,
  localparam int  CNT_W      = $clog2(BEAT_BYTES + 1),
  localparam int  IDX_W      = (BEAT_BYTES > 1) ? $clog2(BEAT_BYTES) : 1
) (
  input  crc_t             state,
  input  logic [CNT_W-1:0] nbytes,
  output crc_t             advanced
);

  typedef crc_mat_t [BEAT_BYTES-1:0] adv_tab_t;

  // Entry k moves the register across k+1 zero bytes.
  function automatic adv_tab_t build_adv();
    adv_tab_t t;
    for (int k = 0; k < BEAT_BYTES; k++) begin
      for (int j = 0; j < CRC_W; j++) begin
        t[k][j] = zero_adv(crc_t'(1) << j, 8 * (k + 1), POLY);
      end
    end
    return t;
  endfunction

  localparam adv_tab_t ADV_T = build_adv();

  logic [IDX_W-1:0] sel;

  always_comb begin
    sel      = IDX_W'(nbytes - CNT_W'(1));
    advanced = mat_vec(ADV_T[sel], state);
  end

endmodule

// File: rtl/lcrc_lane_engine.sv
module lcrc_lane_engine
  import lcrc_pkg::*;
#(
  parameter int   BEAT_BYTES = 16,
  parameter int   LANES      = 4,
  parameter crc_t POLY       = 32'hEDB88320,
  localparam int  DATA_W     = BEAT_BYTES * 8,
  localparam int  CNT_W      = $clog2(BEAT_BYTES + 1),
  localparam int  LANE_BYTES = BEAT_BYTES / LANES,
  localparam int  LANE_W     = LANE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [CNT_W-1:0]  in_nbytes,
  output logic [CRC_W-1:0]  crc_out,
  output logic              crc_done
);

  logic              rdy_q;
  logic              take;
  crc_t              acc_q;
  crc_t              base;
  crc_t              adv;
  crc_t              lane_sum;
  crc_t              next_acc;
  logic [DATA_W-1:0] aligned;
  logic [CNT_W-1:0]  eff_n;
  crc_t              lane_c [LANES];

  assign in_ready = rdy_q;
  assign take     = in_valid && rdy_q;
  assign base     = in_sop ? '0 : acc_q;

  lcrc_tail_align #(
    .BEAT_BYTES(BEAT_BYTES)
  ) u_align (
    .data    (in_data),
    .is_last (in_eop),
    .nbytes  (in_nbytes),
    .aligned (aligned),
    .eff_n   (eff_n)
  );

  lcrc_state_adv #(
    .BEAT_BYTES(BEAT_BYTES),
    .POLY      (POLY)
  ) u_adv (
    .state    (base),
    .nbytes   (eff_n),
    .advanced (adv)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lcrc_lane_contrib #(
      .BEAT_BYTES(BEAT_BYTES),
      .LANE_BYTES(LANE_BYTES),
      .LANE_IDX  (g),
      .POLY      (POLY)
    ) u_lane (
      .lane_data (aligned[g*LANE_W +: LANE_W]),
      .contrib   (lane_c[g])
    );
  end

  always_comb begin
    lane_sum = '0;
    for (int g = 0; g < LANES; g++) lane_sum = lane_sum ^ lane_c[g];
    next_acc = adv ^ lane_sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q    <= 1'b0;
      acc_q    <= '0;
      crc_out  <= '0;
      crc_done <= 1'b0;
    end else begin
      rdy_q    <= 1'b1;
      crc_done <= take && in_eop;
      if (take) acc_q <= next_acc;
      if (take && in_eop) crc_out <= ~next_acc;
    end
  end

  AST_DONE_FOLLOWS_EOP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_eop) |=> crc_done); // R6
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready && in_eop) |=> !crc_done); // R6
  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !crc_done); // R8
  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !crc_done |-> $stable(crc_out)); // R7
  AST_READY_RETURNS: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> in_ready); // R2
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!crc_done && (crc_out == '0) && !in_ready)); // R9

endmodule

// File: tb/lcrc_lane_engine_tb.sv
module lcrc_lane_engine_tb;

  localparam int BB = 16;
  localparam logic [31:0] POLY = 32'hEDB88320;

  typedef struct packed {
    logic [8:0]  len;
    logic [15:0] seed;
    logic        gaps;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{9'd1,   16'h0011, 1'b0}, '{9'd2,   16'h0022, 1'b0},
    '{9'd3,   16'h0033, 1'b0}, '{9'd4,   16'h0044, 1'b1},
    '{9'd5,   16'h0055, 1'b0}, '{9'd6,   16'h0066, 1'b0},
    '{9'd7,   16'h0077, 1'b0}, '{9'd8,   16'h0088, 1'b0},
    '{9'd9,   16'h0099, 1'b0}, '{9'd10,  16'h00AA, 1'b0},
    '{9'd11,  16'h00BB, 1'b0}, '{9'd12,  16'h00CC, 1'b0},
    '{9'd13,  16'h00DD, 1'b0}, '{9'd14,  16'h00EE, 1'b0},
    '{9'd15,  16'h00FF, 1'b0}, '{9'd16,  16'h0101, 1'b0},
    '{9'd17,  16'h0202, 1'b1}, '{9'd31,  16'h0303, 1'b0},
    '{9'd32,  16'h0404, 1'b0}, '{9'd47,  16'h0505, 1'b1},
    '{9'd64,  16'h0606, 1'b0}, '{9'd100, 16'h0707, 1'b1},
    '{9'd200, 16'h0808, 1'b0}, '{9'd256, 16'h0909, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         in_ready;
  logic [127:0] in_data;
  logic         in_sop;
  logic         in_eop;
  logic [4:0]   in_nbytes;
  logic [31:0]  crc_out;
  logic         crc_done;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] pkt [256];

  always #4 clk = ~clk;

  lcrc_lane_engine u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .in_nbytes (in_nbytes),
    .crc_out   (crc_out),
    .crc_done  (crc_done)
  );

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic fill(input int len, input int seed);
    int x;
    x = seed;
    for (int i = 0; i < 256; i++) begin
      x = x * 1103515245 + 12345;
      pkt[i] = (i < len) ? x[23:16] : 8'h00;
    end
  endtask

  // Bit-serial model: zero start, reflected polynomial, inverted result.
  function automatic logic [31:0] ref_crc(input int len);
    logic [31:0] s;
    logic fb;
    s = '0;
    for (int i = 0; i < len; i++) begin
      for (int b = 0; b < 8; b++) begin
        fb = s[0] ^ pkt[i][b];
        s = s >> 1;
        if (fb) s = s ^ POLY;
      end
    end
    return ~s;
  endfunction

  task automatic idle_junk();
    in_valid  = 1'b0;
    in_sop    = 1'b1;
    in_eop    = 1'b1;
    in_nbytes = 5'd1;
    in_data   = {4{32'hDEADBEEF}};
  endtask

  // last_cnt < 0 sends the natural tail count.
  task automatic send(input int len, input int last_cnt, input bit gaps,
                      input bit chk_hold, input logic [31:0] hold_val);
    int nb;
    logic [127:0] d;
    nb = (len + BB - 1) / BB;
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      if (chk_hold && b > 0) check32("R7 output held during next packet", crc_out, hold_val);
      for (int k = 0; k < BB; k++) begin
        d[k*8 +: 8] = ((b * BB + k) < len) ? pkt[b * BB + k] : 8'(8'h5A ^ k);
      end
      in_data  = d;
      in_valid = 1'b1;
      in_sop   = (b == 0);
      in_eop   = (b == nb - 1);
      if (b == nb - 1) in_nbytes = (last_cnt < 0) ? 5'(len - b * BB) : 5'(last_cnt);
      else             in_nbytes = 5'(3 + b);
      if (gaps && b < nb - 1) begin
        @(negedge clk);
        idle_junk();
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_eop   = 1'b0;
  endtask

  task automatic check_result(input string req, input logic [31:0] exp);
    check1({req, " done pulse"}, crc_done, 1'b1);
    check32({req, " checksum"}, crc_out, exp);
    @(negedge clk);
    check1("R6 done is one cycle", crc_done, 1'b0);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] e;
    logic [31:0] prev;
    rst = 1'b1;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    in_nbytes = 5'd0; in_data = '0;
    repeat (3) @(negedge clk);
    check1("R9 done low in reset", crc_done, 1'b0);
    check32("R9 output zero in reset", crc_out, 32'h0);
    check1("R2 ready low in reset", in_ready, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check1("R2 ready after reset", in_ready, 1'b1);

    // Table walk: R1 value, R4 tail lengths, R5 junk counts, R8 junk gaps
    for (int v = 0; v < NV; v++) begin
      fill(int'(VEC[v].len), int'(VEC[v].seed));
      e = ref_crc(int'(VEC[v].len));
      send(int'(VEC[v].len), -1, VEC[v].gaps, 1'b0, 32'h0);
      check_result("R1 R4 R5 R8 table", e);
    end

    // R4: count of 0 on the last beat means a full beat
    fill(32, 77);
    e = ref_crc(32);
    send(32, 0, 1'b0, 1'b0, 32'h0);
    check_result("R4 zero count", e);
    // R4: count above 16 also means a full beat
    fill(48, 91);
    e = ref_crc(48);
    send(48, 20, 1'b0, 1'b0, 32'h0);
    check_result("R4 large count", e);

    // R7: output holds through idle cycles and the next packet
    prev = crc_out;
    repeat (4) @(negedge clk);
    check32("R7 output held while idle", crc_out, prev);
    fill(48, 123);
    e = ref_crc(48);
    send(48, -1, 1'b0, 1'b1, prev);
    check_result("R7 next packet", e);

    // R8: invalid cycle with start/end markers set has no effect
    prev = crc_out;
    @(negedge clk);
    idle_junk();
    @(negedge clk);
    check1("R8 no done on idle markers", crc_done, 1'b0);
    check32("R8 output unchanged", crc_out, prev);
    in_sop = 1'b0; in_eop = 1'b0;

    // R3: stale beats without start are discarded by the start marker
    @(negedge clk);
    in_valid = 1'b1; in_sop = 1'b0; in_eop = 1'b0;
    in_data = {4{32'h12345678}}; in_nbytes = 5'd9;
    @(negedge clk);
    in_data = {4{32'hCAFEF00D}};
    fill(20, 555);
    e = ref_crc(20);
    send(20, -1, 1'b0, 1'b0, 32'h0);
    check_result("R3 start discards stale beats", e);

    // R3: single beat with start and end together
    fill(16, 999);
    e = ref_crc(16);
    send(16, -1, 1'b0, 1'b0, 32'h0);
    check_result("R3 single beat packet", e);

    // R9: reset mid-stream clears the outputs
    @(negedge clk);
    in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b0; in_data = '1;
    rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0;
    @(negedge clk);
    check32("R9 output cleared by reset", crc_out, 32'h0);
    check1("R9 done low after reset", crc_done, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    fill(5, 31);
    e = ref_crc(5);
    send(5, -1, 1'b0, 1'b0, 32'h0);
    check_result("R1 after reset", e);

    finished = 1;
    summary();
    $finish;
  end

endmodule